// File: doc/BRIEF.md
# SPI Core with Mode-Fault Detection

This block is an 8-bit SPI engine that runs either as the clock-generating master or as a selected slave. It carries the serial shifter, the bit counter and a tracker that knows when a byte transfer is in progress. On top of these it watches the select line for a mode fault. A fault sets a sticky flag and can raise an error interrupt. The reaction depends on the role. As master, the core switches itself off and hands the pins back to general port logic. As slave, it only records the fault and keeps running.

Software drives a register-style port: a write strobe that loads enable, role, clock phase, clock polarity and interrupt enable; a transmit-byte write; and a strobe that clears the fault flag. When a slave transfer counts as begun depends on the phase setting. With phase 0, pulling select low starts the byte at once and drives the first data bit. With phase 1, nothing starts until the clock leaves idle. So a select pulse with no clock is a fault only in phase 0. Select, clock and slave data in pass through a two-stage synchronizer. The master clock runs at a fixed divider of the system clock.

Top module: `spi_mf_core`

## Requirements
- R1: A change on the select or clock pin affects core state at the third rising clock edge after it.
- R2: While enabled as master, a low level on select sets the fault flag, clears the enable bit and sets transmit-empty. The role bit keeps its value.
- R3: Whenever the enable bit is 0, including after a master fault and after reset, the clock, MOSI and MISO output enables are all 0.
- R4: Slave, phase 0: a falling select starts the transfer and puts bit 7 of the transmit byte on MISO. A select high again before the byte ends, even with no clock edges, sets the fault flag.
- R5: Slave, phase 1: selecting and deselecting with no clock edges leaves the fault flag at 0.
- R6: Slave, either phase: select rising partway through a byte sets the fault flag, and the enable bit stays 1.
- R7: A slave byte of eight clock pulses, MSB first, ends with no fault. The byte received on MOSI appears on rx_data_o with a one-cycle rx_valid_o pulse. The transmit byte is shifted out on MISO, MSB first.
- R8: The fault flag stays 1 until a clear strobe. A fault detected in the same cycle as the clear leaves it at 1.
- R9: irq_o is 1 exactly while the fault flag is 1 and the interrupt-enable bit is 1.
- R10: Writing enable 0 and then 1 resets the in-progress tracker and the bit counter. A select rise after that is not a fault, and the next byte is received intact.
- R11: As master, a written byte is sent on MOSI with 8 clock pulses, MSB first. The clock idles at the polarity level, and the byte looped back on MISO is received. Transmit-empty goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Load the control fields below |
| ctl_en_i | input | 1 | Enable value |
| ctl_mst_i | input | 1 | Role value, 1 = master |
| ctl_cpha_i | input | 1 | Clock phase value |
| ctl_cpol_i | input | 1 | Clock idle level value |
| ctl_errie_i | input | 1 | Error interrupt enable value |
| fault_clr_i | input | 1 | Clear strobe for the fault flag |
| tx_wr_i | input | 1 | Write the transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| en_o | output | 1 | Enable bit |
| mst_o | output | 1 | Role bit |
| fault_o | output | 1 | Sticky mode-fault flag |
| txe_o | output | 1 | Transmit byte taken or discarded |
| irq_o | output | 1 | Error interrupt request |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse at byte end |
| sck_i | input | 1 | Serial clock pin in (slave) |
| sck_o | output | 1 | Serial clock pin out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin in (slave) |
| mosi_o | output | 1 | MOSI pin out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin in (master) |
| miso_o | output | 1 | MISO pin out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Select pin, active low |

## Verification
Pin changes reach the logic through two synchronizer flops and an edge-history flop. The fault flag, the enable bit and the start of a slave transfer therefore change at the third rising edge after the bench moves select. The bench samples at the falling edge after the second rising edge (still old) and after the third (new). That is how R1 and the same-cycle clear of R8 are pinned down. A slave output bit moves three edges after the clock pin edge that shifts it. The bench holds each clock level for eight cycles and reads MISO just before the edge on which a receiver would sample. A master byte takes sixteen half periods of the fixed divider, and the bench reads the result only after that window has closed.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  typedef struct packed {
    logic errie;
    logic cpol;
    logic cpha;
    logic mst;
    logic en;
  } spi_ctl_t;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {STAGES{RST_VAL}};
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_mf_mclk.sv
module spi_mf_mclk #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic phase_o,
  output logic lead_o,
  output logic trail_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] div_q;
  logic          ph_q;
  logic          tick;

  assign tick = run_i && (div_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign lead_o  = tick & ~ph_q;
  assign trail_o = tick & ph_q;
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         abort_i,
  input  logic         start_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         cpha_i,
  input  logic         din_i,
  input  logic [W-1:0] tx_i,
  output logic         dout_o,
  output logic [W-1:0] rx_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, rx_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, first_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; rx_q <= '0; cnt_q <= '0;
      busy_q <= 1'b0; first_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i || abort_i) begin
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else if (start_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        sh_q    <= tx_i;
        first_q <= ~lead_i;  // phase 1 slave: start edge is the first lead
      end else if (busy_q) begin
        if (lead_i) begin
          if (!cpha_i) rx_q <= {rx_q[W-2:0], din_i};
          else begin
            if (!first_q) sh_q <= {sh_q[W-2:0], 1'b0};
            first_q <= 1'b0;
          end
        end
        if (trail_i) begin
          if (!cpha_i) sh_q <= {sh_q[W-2:0], 1'b0};
          else         rx_q <= {rx_q[W-2:0], din_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign dout_o = sh_q[W-1];
  assign rx_o   = rx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r7_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && en_i && !abort_i) |=> (busy_o && cnt_q == '0));
endmodule

// File: rtl/spi_mf_core.sv
module spi_mf_core
  import spi_mf_pkg::*;
#(
  parameter int W    = 8,
  parameter int HALF = 4,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_wr_i,
  input  logic         ctl_en_i,
  input  logic         ctl_mst_i,
  input  logic         ctl_cpha_i,
  input  logic         ctl_cpol_i,
  input  logic         ctl_errie_i,
  input  logic         fault_clr_i,
  input  logic         tx_wr_i,
  input  logic [W-1:0] tx_data_i,
  output logic         en_o,
  output logic         mst_o,
  output logic         fault_o,
  output logic         txe_o,
  output logic         irq_o,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe_o,
  input  logic         mosi_i,
  output logic         mosi_o,
  output logic         mosi_oe_o,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe_o,
  input  logic         ss_ni
);
  spi_ctl_t     ctl_q;
  logic [W-1:0] txbuf_q;
  logic         txe_q, fault_q;
  logic         s_ss, s_sck, s_mosi, ss_q, sck_q;
  logic         master_on, slave_on;
  logic         ss_fall, ss_rise, s_lead, s_trail;
  logic         m_lead, m_trail, m_phase;
  logic         busy, done, dout;
  logic         s_start, m_start, start, lead, trail, din, abort;
  logic         mfault, sfault;

  spi_mf_sync #(.W(3), .STAGES(SYNC), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({ss_ni, sck_i, mosi_i}),
    .q_o({s_ss, s_sck, s_mosi})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      ss_q  <= s_ss;
      sck_q <= s_sck;
    end
  end

  assign master_on = ctl_q.en & ctl_q.mst;
  assign slave_on  = ctl_q.en & ~ctl_q.mst;
  assign ss_fall   = ss_q & ~s_ss;
  assign ss_rise   = ~ss_q & s_ss;
  assign s_lead    = (sck_q == ctl_q.cpol) && (s_sck != ctl_q.cpol) && !s_ss;
  assign s_trail   = (sck_q != ctl_q.cpol) && (s_sck == ctl_q.cpol) && !s_ss;

  // start point of a slave byte depends on phase
  assign s_start = slave_on & (ctl_q.cpha ? (s_lead & ~busy) : ss_fall);
  assign m_start = master_on & ~busy & ~txe_q & s_ss;
  assign start   = s_start | m_start;
  assign lead    = master_on ? m_lead  : s_lead;
  assign trail   = master_on ? m_trail : s_trail;
  assign din     = master_on ? miso_i  : s_mosi;
  assign abort   = slave_on & ss_rise;
  assign mfault  = master_on & ~s_ss;
  assign sfault  = slave_on & busy & ss_rise;

  spi_mf_mclk #(.HALF(HALF)) u_mclk (
    .clk_i, .rst_ni,
    .run_i(master_on & busy),
    .phase_o(m_phase),
    .lead_o(m_lead),
    .trail_o(m_trail)
  );

  spi_mf_shifter #(.W(W)) u_shift (
    .clk_i, .rst_ni,
    .en_i(ctl_q.en),
    .abort_i(abort),
    .start_i(start),
    .lead_i(lead),
    .trail_i(trail),
    .cpha_i(ctl_q.cpha),
    .din_i(din),
    .tx_i(txbuf_q),
    .dout_o(dout),
    .rx_o(rx_data_o),
    .busy_o(busy),
    .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      txbuf_q <= '0;
      txe_q   <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      if (ctl_wr_i) begin
        ctl_q.en    <= ctl_en_i;
        ctl_q.mst   <= ctl_mst_i;
        ctl_q.cpha  <= ctl_cpha_i;
        ctl_q.cpol  <= ctl_cpol_i;
        ctl_q.errie <= ctl_errie_i;
      end
      if (mfault) ctl_q.en <= 1'b0;  // master fault wins over a write
      if (tx_wr_i) txbuf_q <= tx_data_i;
      if (mfault)       txe_q <= 1'b1;
      else if (tx_wr_i) txe_q <= 1'b0;
      else if (start)   txe_q <= 1'b1;
      if (mfault || sfault) fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign en_o       = ctl_q.en;
  assign mst_o      = ctl_q.mst;
  assign fault_o    = fault_q;
  assign txe_o      = txe_q;
  assign irq_o      = fault_q & ctl_q.errie;
  assign rx_valid_o = done;
  assign sck_o      = ctl_q.cpol ^ m_phase;
  assign sck_oe_o   = master_on;
  assign mosi_o     = dout;
  assign mosi_oe_o  = master_on;
  assign miso_o     = dout;
  assign miso_oe_o  = slave_on & ~s_ss;

  a_r2_master_fault_reaction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_on && !s_ss && !ctl_wr_i) |=> (!en_o && txe_o && mst_o && fault_o));
  a_r3_pins_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> (!sck_oe_o && !mosi_oe_o && !miso_oe_o));
  a_r6_slave_fault_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfault && !ctl_wr_i) |=> (en_o && fault_o));
  a_r8_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);
endmodule

// File: tb/spi_mf_core_bench.sv
module spi_mf_core_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, c_en = 0, c_mst = 0, c_cpha = 0, c_cpol = 0, c_errie = 0;
  logic fclr = 0, tx_wr = 0;
  logic [7:0] tx_data = 0;
  logic sck = 0, mosi = 0, ss_n = 1, loop = 0;
  logic en_o, mst_o, fault_o, txe_o, irq_o, rx_valid_o;
  logic [7:0] rx_data_o;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, miso_in;
  int n_chk = 0, n_fail = 0, vcnt = 0;
  bit done_flag = 0;
  logic cpha_b = 0, cpol_b = 0;

  assign miso_in = loop ? mosi_o : 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (rx_valid_o) vcnt++;

  spi_mf_core u_spi_mf_core (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_wr_i(ctl_wr), .ctl_en_i(c_en), .ctl_mst_i(c_mst), .ctl_cpha_i(c_cpha),
    .ctl_cpol_i(c_cpol), .ctl_errie_i(c_errie), .fault_clr_i(fclr),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .en_o, .mst_o, .fault_o, .txe_o, .irq_o, .rx_data_o, .rx_valid_o,
    .sck_i(sck), .sck_o, .sck_oe_o, .mosi_i(mosi), .mosi_o, .mosi_oe_o,
    .miso_i(miso_in), .miso_o, .miso_oe_o, .ss_ni(ss_n)
  );

  function automatic bit exp_fault(input logic cpha, input int nb);
    if (nb >= 8) return 1'b0;
    return cpha ? (nb > 0) : 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic en, mst, cpha, cpol, errie);
    @(negedge clk);
    c_en = en; c_mst = mst; c_cpha = cpha; c_cpol = cpol; c_errie = errie; ctl_wr = 1;
    cpha_b = cpha; cpol_b = cpol;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic txw(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic clr_fault();
    @(negedge clk); fclr = 1;
    @(negedge clk); fclr = 0;
  endtask

  task automatic drive_bit(input logic b, output logic m);
    if (!cpha_b) begin
      mosi = b; wait_n(4); m = miso_o; sck = ~cpol_b; wait_n(8); sck = cpol_b; wait_n(4);
    end else begin
      sck = ~cpol_b; mosi = b; wait_n(8); m = miso_o; sck = cpol_b; wait_n(8);
    end
  endtask

  task automatic slave_xfer(input int nb, input logic [7:0] mo, output logic [7:0] cap);
    logic m;
    cap = 0;
    ss_n = 0; wait_n(8);
    for (int i = 0; i < nb; i++) begin
      drive_bit(mo[7-i], m);
      cap[7-i] = m;
    end
    wait_n(4); ss_n = 1; wait_n(6);
  endtask

  initial begin
    logic [7:0] cap, mo, tb;
    int nb, v0;
    logic rc, rp, re;
    void'($urandom(32'h5eed_0042));
    wait_n(3); rst_n = 1; wait_n(2);

    // reset state
    chk("R3 reset en", en_o, 0);
    chk("R3 reset oe", {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);
    chk("R8 reset fault", fault_o, 0);
    chk("R9 reset irq", irq_o, 0);
    chk("R2 reset txe", txe_o, 1);

    // R4: phase 0 select drives MSB, select pulse without clock faults
    sck = 0; cfg(1, 0, 0, 0, 1); txw(8'hA5);
    ss_n = 0; wait_n(6);
    chk("R4 miso msb", miso_o, 1);
    chk("R4 miso oe", miso_oe_o, 1);
    ss_n = 1; wait_n(6);
    chk("R4 fault no clock", fault_o, 1);
    chk("R6 en kept", en_o, 1);
    chk("R9 irq with errie", irq_o, 1);
    wait_n(10);
    chk("R8 sticky", fault_o, 1);
    clr_fault(); wait_n(1);
    chk("R8 cleared", fault_o, 0);

    // R5: phase 1 select pulse without clock
    cfg(1, 0, 1, 0, 1);
    ss_n = 0; wait_n(8); ss_n = 1; wait_n(8);
    chk("R5 no fault phase1", fault_o, 0);

    // R6: mid-byte release both phases, errie 0 keeps irq low
    for (int p = 0; p < 2; p++) begin
      cfg(1, 0, p[0], 1, 0); sck = 1; wait_n(4);
      slave_xfer(3, 8'h3C, cap);
      chk("R6 mid-byte fault", fault_o, 1);
      chk("R6 en kept", en_o, 1);
      chk("R9 irq masked", irq_o, 0);
      clr_fault();
    end

    // R8: set in the same cycle as clear
    sck = 0; cfg(1, 0, 0, 0, 0);
    ss_n = 0; wait_n(8);
    ss_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); fclr = 1;
    @(negedge clk); fclr = 0;
    chk("R8 set beats clear", fault_o, 1);
    clr_fault(); wait_n(1);
    chk("R8 clear", fault_o, 0);

    // R10: enable toggle resets tracker and counter
    cfg(1, 0, 1, 0, 0);
    ss_n = 0; wait_n(8);
    drive_bit(1'b1, rc); drive_bit(1'b0, rc);
    cfg(0, 0, 1, 0, 0); cfg(1, 0, 1, 0, 0);
    ss_n = 1; wait_n(8);
    chk("R10 no fault after toggle", fault_o, 0);
    txw(8'h96); v0 = vcnt;
    slave_xfer(8, 8'h4B, cap);
    chk("R10 byte after toggle", rx_data_o, 8'h4B);
    chk("R10 miso after toggle", cap, 8'h96);

    // random slave transfers, R4..R7, R9
    for (int it = 0; it < 14; it++) begin
      rp = 1'($urandom); rc = 1'($urandom); re = 1'($urandom);
      nb = $urandom_range(0, 8); mo = 8'($urandom); tb = 8'($urandom);
      sck = rc; wait_n(4);
      cfg(1, 0, rp, rc, re); txw(tb); v0 = vcnt;
      slave_xfer(nb, mo, cap);
      chk($sformatf("R6 rnd fault cpha=%0d nb=%0d", rp, nb), fault_o, exp_fault(rp, nb));
      chk("R9 rnd irq", irq_o, exp_fault(rp, nb) & re);
      chk("R7 rnd valid count", vcnt - v0, (nb == 8) ? 1 : 0);
      if (nb == 8) begin
        chk("R7 rnd rx", rx_data_o, mo);
        chk("R7 rnd miso", cap, tb);
      end
      clr_fault();
    end

    // R11: master loopback both phases, clock idle high
    for (int p = 0; p < 2; p++) begin
      loop = 1; tb = 8'($urandom);
      cfg(1, 1, p[0], 1, 0); wait_n(2);
      chk("R11 idle clock", sck_o, 1);
      chk("R11 oe", {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b110);
      v0 = vcnt;
      txw(tb); wait_n(90);
      chk("R11 loop rx", rx_data_o, tb);
      chk("R11 txe back", txe_o, 1);
      chk("R11 clock idle after", sck_o, 1);
      chk("R11 valid", vcnt - v0, 1);
      chk("R11 no fault", fault_o, 0);
    end

    // R1/R2/R3: master fault partway through a byte
    cfg(1, 1, 0, 0, 1); txw(8'hC3); wait_n(20);
    ss_n = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 not yet", {fault_o, en_o}, 2'b01);
    @(posedge clk); @(negedge clk);
    chk("R1 fault on third edge", fault_o, 1);
    chk("R2 en cleared", en_o, 0);
    chk("R2 mst kept", mst_o, 1);
    chk("R2 txe set", txe_o, 1);
    chk("R9 irq master", irq_o, 1);
    chk("R3 oe released", {sck_oe_o, mosi_oe_o, miso_oe_o}, 0);
    wait_n(10);
    chk("R3 clock idle", sck_o, 0);
    ss_n = 1; loop = 0;
    clr_fault();

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule